// File: doc/BRIEF.md
# Command-Block Memory Copy Engine

This block is a single-channel memory-to-memory copy engine that is a bus master. Software prepares a three-word command block in memory that gives a source pointer, a destination pointer and a length in bytes. It then writes the address of that block into the engine's start register and goes on with other work. The engine requests the memory bus and reads the command block itself. It then copies the data one 32-bit word at a time, each word a read from the source followed by a write to the destination. When the whole copy is done, it raises a sticky interrupt flag.

The bus port uses a request/grant handshake. The engine raises its request and waits for the grant before it makes any access. Each access is held until the memory acknowledges it, and the engine drops the request to hand the bus back. A mode bit in the start write chooses between two policies. In burst mode the bus stays with the engine from the command fetch to the final write. In single-cycle mode the engine gives the bus up after the command fetch and after every copied word, then asks for it again before the next word. Other masters, including the CPU's path to main memory, are locked out only while the engine owns the bus.

Top module: `dma_desc_engine`

## Requirements
- R1: A register write with `cfg_sel`=0 while idle starts a transfer. The command block address is taken from `cfg_wdata` with bits [1:0] cleared, bit 0 selects the mode (1 = burst, 0 = single-cycle), and bit 1 is ignored. `busy` is high from the next cycle.
- R2: The command block is read as three word reads, in this order: address A gives the source pointer, A+4 the destination pointer, and A+8 the byte count.
- R3: The engine copies ceil(count/4) words. Source word i goes to destination word i, in ascending order, and no word beyond the last is written.
- R4: Every bus access (`m_valid`) happens only while both `m_req` and `m_gnt` are high. An access holds its address until `m_ack` completes it, and read data is taken on `m_ack`.
- R5: In burst mode, `m_req` rises once per transfer and stays high from the command fetch until the last write is acknowledged.
- R6: In single-cycle mode, `m_req` drops for at least one cycle after the command fetch and after every copied word except the last. A transfer of N>0 words therefore raises `m_req` 1+N times.
- R7: A byte count of zero causes no copy access. The transfer completes right after the command fetch and still raises the interrupt.
- R8: `irq` is set in the same cycle that `busy` falls at the end of a transfer. It then stays high until a register write with `cfg_sel`=1 clears it. If completion and clear happen in the same cycle, the set wins.
- R9: A start write (`cfg_sel`=0) while `busy` is high is ignored. The running transfer is unchanged, and no second transfer follows.
- R10: During and after reset, `busy`, `irq`, `m_req` and `m_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | CPU register write strobe |
| cfg_sel | input | 1 | Register select: 0 = start, 1 = interrupt clear |
| cfg_wdata | input | 32 | CPU write data |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Sticky completion interrupt |
| m_req | output | 1 | Bus request; dropped to release the bus |
| m_gnt | input | 1 | Bus grant |
| m_valid | output | 1 | Access in progress |
| m_we | output | 1 | Access is a write |
| m_addr | output | 32 | Byte address of the access |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data, valid with m_ack |
| m_ack | input | 1 | Access completion |

## Verification
A corrupted pointer or fetch index shows up within the first three reads after a start, as a command-block address out of order. If it shows up later, it appears as destination words that do not match the source, or as a word written past the end. A wrong remaining-word count either overwrites the guard word after the destination or ends the copy early. In both cases the error is visible by the time `irq` rises. A wrong mode decision changes how many times `m_req` rises per transfer, and the checks inside the RTL catch it at the first word boundary.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int CNT_W      = 32;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BYTE_SH    = $clog2(WORD_BYTES);
  localparam int DESC_WORDS = 3;
  localparam int FIDX_W     = $clog2(DESC_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start write
    ST_FREQ,   // requesting the bus for the command fetch
    ST_FRD,    // reading the command block words
    ST_GAP,    // bus released between units (single-cycle mode)
    ST_CREQ,   // requesting the bus again for the next unit
    ST_RD,     // reading one source word
    ST_WR,     // writing one destination word
    ST_DONE    // completion, one cycle
  } dma_state_e;

  // Number of whole words needed to cover a byte count (rounded up).
  function automatic logic [CNT_W-1:0] round_up_words(input logic [CNT_W-1:0] nbytes);
    logic [CNT_W-1:0] tail;
    tail = nbytes & CNT_W'(WORD_BYTES - 1);
    return (nbytes >> BYTE_SH) + ((tail != '0) ? CNT_W'(1) : CNT_W'(0));
  endfunction

  // Clear the byte-offset bits of an address.
  function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(WORD_BYTES - 1);
  endfunction

  // Address of the next word.
  function automatic logic [ADDR_W-1:0] next_word(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(WORD_BYTES);
  endfunction

  // Address of word idx inside the command block at base.
  function automatic logic [ADDR_W-1:0] desc_slot(input logic [ADDR_W-1:0] base,
                                                  input logic [FIDX_W-1:0] idx);
    return base + (ADDR_W'(idx) << BYTE_SH);
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              busy,
  input  logic              xfer_done,
  output logic              start_go,
  output logic [ADDR_W-1:0] desc_base,
  output logic              burst_mode,
  output logic              irq
);

  logic start_wr;
  logic clear_wr;

  assign start_wr = cfg_wr && !cfg_sel;
  assign clear_wr = cfg_wr && cfg_sel;
  assign start_go = start_wr && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_base  <= '0;
      burst_mode <= 1'b0;
    end else if (start_go) begin
      desc_base  <= word_align(ADDR_W'(cfg_wdata));
      burst_mode <= cfg_wdata[0];
    end
  end

  // Set has priority over clear.
  always_ff @(posedge clk) begin
    if (!rst_n)         irq <= 1'b0;
    else if (xfer_done) irq <= 1'b1;
    else if (clear_wr)  irq <= 1'b0;
  end

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_wr) |=> ($stable(desc_base) && $stable(burst_mode)));

  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> irq);

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clear_wr) |=> irq);

  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && !xfer_done) |=> !irq);

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic              burst_mode,
  input  logic              m_gnt,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_ack,
  output logic              busy,
  output logic              xfer_done,
  output logic              m_req,
  output logic              m_valid,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata
);

  localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(DESC_WORDS - 1);

  dma_state_e        state, state_n;
  logic [FIDX_W-1:0] fidx;
  logic [ADDR_W-1:0] src_ptr;
  logic [ADDR_W-1:0] dst_ptr;
  logic [CNT_W-1:0]  words_left;
  logic [DATA_W-1:0] data_q;

  // Named internal events, used by the next-state logic and the assertions.
  logic              fetch_done;
  logic              unit_done;
  logic              last_unit;
  logic [CNT_W-1:0]  fetched_words;

  assign fetched_words = round_up_words(CNT_W'(m_rdata));
  assign fetch_done    = (state == ST_FRD) && m_ack && (fidx == FIDX_LAST);
  assign unit_done     = (state == ST_WR) && m_ack;
  assign last_unit     = (words_left == CNT_W'(1));

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE: if (start_go) state_n = ST_FREQ;
      ST_FREQ: if (m_gnt)    state_n = ST_FRD;
      ST_FRD:  if (fetch_done) begin
                 if (fetched_words == '0) state_n = ST_DONE;
                 else if (burst_mode)     state_n = ST_RD;
                 else                     state_n = ST_GAP;
               end
      ST_GAP:  state_n = ST_CREQ;
      ST_CREQ: if (m_gnt) state_n = ST_RD;
      ST_RD:   if (m_ack) state_n = ST_WR;
      ST_WR:   if (unit_done) begin
                 if (last_unit)       state_n = ST_DONE;
                 else if (burst_mode) state_n = ST_RD;
                 else                 state_n = ST_GAP;
               end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fidx       <= '0;
      src_ptr    <= '0;
      dst_ptr    <= '0;
      words_left <= '0;
      data_q     <= '0;
    end else begin
      if (state == ST_IDLE && start_go) fidx <= '0;
      if (state == ST_FRD && m_ack) begin
        case (fidx)
          FIDX_W'(0): src_ptr    <= word_align(ADDR_W'(m_rdata));
          FIDX_W'(1): dst_ptr    <= word_align(ADDR_W'(m_rdata));
          default:    words_left <= fetched_words;
        endcase
        fidx <= fidx + FIDX_W'(1);
      end
      if (state == ST_RD && m_ack) data_q <= m_rdata;
      if (unit_done) begin
        src_ptr    <= next_word(src_ptr);
        dst_ptr    <= next_word(dst_ptr);
        words_left <= words_left - CNT_W'(1);
      end
    end
  end

  always_comb begin
    m_addr = '0;
    case (state)
      ST_FRD:  m_addr = desc_slot(desc_base, fidx);
      ST_RD:   m_addr = src_ptr;
      ST_WR:   m_addr = dst_ptr;
      default: m_addr = '0;
    endcase
  end

  assign m_valid   = (state == ST_FRD) || (state == ST_RD) || (state == ST_WR);
  assign m_req     = m_valid || (state == ST_FREQ) || (state == ST_CREQ);
  assign m_we      = (state == ST_WR);
  assign m_wdata   = data_q;
  assign busy      = (state != ST_IDLE);
  assign xfer_done = (state == ST_DONE);

  p_access_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_req && m_gnt));

  p_access_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ack) |=> (m_valid && $stable(m_addr) && $stable(m_we)));

  p_burst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && burst_mode && !last_unit) |=> m_req);

  p_burst_after_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done && burst_mode && fetched_words != '0) |=> m_req);

  p_single_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !burst_mode && !last_unit) |=> !m_req);

  p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done && fetched_words == '0) |=> (xfer_done && !m_valid));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !busy);

endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import dma_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              busy,
  output logic              irq,
  output logic              m_req,
  input  logic              m_gnt,
  output logic              m_valid,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_ack
);

  logic              start_go;
  logic              xfer_done;
  logic [ADDR_W-1:0] desc_base;
  logic              burst_mode;

  dma_cfg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .busy       (busy),
    .xfer_done  (xfer_done),
    .start_go   (start_go),
    .desc_base  (desc_base),
    .burst_mode (burst_mode),
    .irq        (irq)
  );

  dma_xfer_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_go   (start_go),
    .desc_base  (desc_base),
    .burst_mode (burst_mode),
    .m_gnt      (m_gnt),
    .m_rdata    (m_rdata),
    .m_ack      (m_ack),
    .busy       (busy),
    .xfer_done  (xfer_done),
    .m_req      (m_req),
    .m_valid    (m_valid),
    .m_we       (m_we),
    .m_addr     (m_addr),
    .m_wdata    (m_wdata)
  );

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> (!busy && !irq && !m_req && !m_valid));

  p_irq_with_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $rose(irq) || irq);

endmodule

// File: tb/dma_desc_engine_tb.sv
module dma_desc_engine_tb;

  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        busy, irq, m_req, m_valid, m_we;
  logic        m_gnt, m_ack;
  logic [31:0] m_addr, m_wdata, m_rdata;

  logic [31:0] mem [0:1023];
  logic        pl_we = 1'b0;
  logic [9:0]  pl_addr = '0;
  logic [31:0] pl_data = '0;
  logic [31:0] rd_log [0:63];
  int          rd_total, wr_total, req_rises;
  logic        req_q;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_desc_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .busy(busy), .irq(irq), .m_req(m_req), .m_gnt(m_gnt), .m_valid(m_valid),
    .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack)
  );

  // Arbiter and memory model; the only writer of mem.
  always @(posedge clk) begin
    if (pl_we) mem[pl_addr] <= pl_data;
    if (!rst_n) begin
      m_gnt <= 1'b0; m_ack <= 1'b0; m_rdata <= '0;
      rd_total <= 0; wr_total <= 0; req_rises <= 0; req_q <= 1'b0;
    end else begin
      req_q <= m_req;
      if (m_req && !req_q) req_rises <= req_rises + 1;
      m_gnt <= m_req ? (m_gnt | ($urandom_range(0, 1) == 1)) : 1'b0;
      if (m_valid && !m_ack && ($urandom_range(0, 2) != 0)) begin
        m_ack <= 1'b1;
        if (m_we) begin
          mem[m_addr[11:2]] <= m_wdata;
          wr_total <= wr_total + 1;
        end else begin
          m_rdata <= mem[m_addr[11:2]];
          rd_log[rd_total[5:0]] <= m_addr;
          rd_total <= rd_total + 1;
        end
      end else begin
        m_ack <= 1'b0;
      end
    end
  end

  function automatic int exp_words(input int nbytes);
    return (nbytes + 3) / 4;
  endfunction

  function automatic int exp_rises(input bit burst, input int nwords);
    if (burst || nwords == 0) return 1;
    return nwords + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input int w, input logic [31:0] d);
    pl_we = 1'b1; pl_addr = 10'(w); pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic cfg_write(input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_xfer(input int dw, input int sw, input int tw, input int nbytes,
                          input bit burst, input bit poke_busy);
    int nw, rd0, wr0, rs0;
    logic [31:0] exp_data [0:15];
    bit got;
    nw = exp_words(nbytes);
    @(negedge clk);
    poke(dw, 32'(sw * 4));
    poke(dw + 1, 32'(tw * 4));
    poke(dw + 2, 32'(nbytes));
    for (int i = 0; i <= nw; i++) begin
      exp_data[i] = $urandom;
      poke(sw + i, exp_data[i]);
      poke(tw + i, SENT);
    end
    if (poke_busy) begin
      poke(900, 32'(sw * 4)); poke(901, 32'(700 * 4)); poke(902, 32'd16);
      poke(700, SENT);
    end
    rd0 = rd_total; wr0 = wr_total; rs0 = req_rises;
    // bit 1 set on purpose: must be ignored (R1)
    cfg_write(1'b0, 32'(dw * 4) | 32'h2 | 32'(burst));
    chk(busy === 1'b1, "R1 busy after start", 32'(busy), 1);
    if (poke_busy) begin
      repeat (4) @(negedge clk);
      chk(busy === 1'b1, "R9 still busy", 32'(busy), 1);
      cfg_write(1'b0, 32'(900 * 4));
    end
    got = 1'b0;
    for (int c = 0; c < 4000 && !got; c++) begin
      @(negedge clk);
      if (irq) got = 1'b1;
    end
    chk(got, "R8 irq raised", 32'(got), 1);
    chk(busy === 1'b0, "R8 busy low with irq", 32'(busy), 0);
    for (int k = 0; k < 3; k++)
      chk(rd_log[6'(rd0 + k)] == 32'((dw + k) * 4), "R2 fetch order",
          rd_log[6'(rd0 + k)], 32'((dw + k) * 4));
    for (int i = 0; i < nw; i++)
      chk(mem[tw + i] == exp_data[i], "R3 copied word", mem[tw + i], exp_data[i]);
    chk(mem[tw + nw] == SENT, "R3 no overrun", mem[tw + nw], SENT);
    chk(wr_total - wr0 == nw, "R3 R7 write count", 32'(wr_total - wr0), 32'(nw));
    chk(req_rises - rs0 == exp_rises(burst, nw), burst ? "R5 request count" : "R6 request count",
        32'(req_rises - rs0), 32'(exp_rises(burst, nw)));
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      chk(busy === 1'b0, "R9 no second transfer", 32'(busy), 0);
      chk(mem[700] == SENT, "R9 ignored block untouched", mem[700], SENT);
      chk(rd_total - rd0 == 3 + nw, "R9 read count", 32'(rd_total - rd0), 32'(3 + nw));
    end
    repeat (3) @(negedge clk);
    chk(irq === 1'b1, "R8 irq sticky", 32'(irq), 1);
    cfg_write(1'b1, 32'h0);
    chk(irq === 1'b0, "R8 irq cleared", 32'(irq), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(!busy && !irq && !m_req && !m_valid, "R10 reset state",
        {28'd0, busy, irq, m_req, m_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !irq && !m_req && !m_valid, "R10 after reset",
        {28'd0, busy, irq, m_req, m_valid}, 32'd0);

    run_xfer(0, 64, 300, 0, 1'b1, 1'b0);   // R7 zero length, burst
    run_xfer(4, 64, 300, 0, 1'b0, 1'b0);   // R7 zero length, single
    run_xfer(8, 70, 310, 1, 1'b0, 1'b0);   // one byte rounds to one word
    run_xfer(12, 80, 320, 5, 1'b1, 1'b0);  // five bytes, two words
    run_xfer(16, 90, 340, 32, 1'b0, 1'b1); // R9 start while busy
    run_xfer(20, 100, 360, 36, 1'b1, 1'b0);
    for (int t = 0; t < 12; t++) begin
      run_xfer(24 + 4 * (t % 8), 64 + int'($urandom_range(0, 40)),
               256 + int'($urandom_range(0, 200)), int'($urandom_range(0, 48)),
               bit'($urandom_range(0, 1)), 1'b0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

endmodule